// File: doc/BRIEF.md
# Carrier Frequency Offset Derotator

This block strips a known carrier frequency offset from a stream of complex time-domain baseband samples. The offset arrives as two words: a coarse part counted in whole subcarrier spacings and a fine part counted in fractions of a spacing. Their sum is the phase step per sample. A phase register advances by that step on every accepted sample. Each sample is turned back by the phase it carries.

The sine and cosine of the current phase are not read from a table. The two top bits of the phase pick a quadrant, and a pipelined CORDIC computes the remaining angle, which lies within ±45 degrees. Four real products, each held in its own register, combine into the corrected in-phase and quadrature outputs. These outputs are rounded and clamped to the input width. The sample data travels beside the CORDIC through matching registers, so each sample meets its own phase.

Top module: `freq_offset_comp`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and out_i and out_q are 0. The phase register restarts at 0, so the first sample accepted after any reset leaves unchanged apart from rounding.
- R2: Phase is 16 bits, where 65536 is one full turn. The step is int_off·32 + frac_off. Both words are signed two's complement and sign-extended, which gives one subcarrier of a 2048-point transform per sample for each unit of int_off. The sum wraps modulo 65536.
- R3: Sample k uses phase_k, where phase_0 = 0 and phase_(k+1) = phase_k + step_k. Here step_k is formed from the offset words present with sample k.
- R4: With φ = 2π·phase/65536, out_i = I·cos φ + Q·sin φ and out_q = Q·cos φ − I·sin φ. The result is within ±2 LSB of the exact rounded value.
- R5: R4 holds over all four quadrants, including the exact multiples of 45 degrees where the quadrant choice switches.
- R6: Results are rounded to the nearest integer and saturated to the signed 12-bit range [−2048, 2047].
- R7: On a cycle with in_valid low, the data and offset inputs have no effect and the phase does not advance.
- R8: A sample presented with in_valid high appears with out_valid high after the 18th rising edge, counting the capturing edge as the first. There is exactly one output per input, in input order, and gaps are preserved.
- R9: Negative int_off turns the phase backward and wraps through zero correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 12 | In-phase sample, signed |
| in_q | input | 12 | Quadrature sample, signed |
| int_off | input | 10 | Whole-subcarrier offset, signed |
| frac_off | input | 6 | Fractional offset in 1/32 subcarrier, signed |
| out_valid | output | 1 | Corrected sample strobe |
| out_i | output | 12 | Corrected in-phase sample, signed |
| out_q | output | 12 | Corrected quadrature sample, signed |

## Verification
A bad phase register value shows up on the very next output as a rotation error. Because the phase accumulates, the error then persists on every later sample, so a single mis-step is caught within 18 cycles and never heals. A wrong quadrant choice or arctangent constant gives errors of whole multiples of 90 degrees, or drifting errors that depend on the angle. A data path out of step with the phase path pairs samples with their neighbours' phases. Both are exposed by stepping through all eight 45-degree points and by random offsets checked against a real-valued model.

// File: rtl/fc_pkg.sv
package fc_pkg;
  // angle width inside the CORDIC: 2^ANG_W units per full turn
  localparam int ANG_W = 18;

  // arctan(2^-idx) in ANG_W turn units
  function automatic int atan_step(input int idx);
    case (idx)
      0:  atan_step = 32768;
      1:  atan_step = 19344;
      2:  atan_step = 10221;
      3:  atan_step = 5188;
      4:  atan_step = 2604;
      5:  atan_step = 1303;
      6:  atan_step = 652;
      7:  atan_step = 326;
      8:  atan_step = 163;
      9:  atan_step = 81;
      10: atan_step = 41;
      11: atan_step = 20;
      12: atan_step = 10;
      13: atan_step = 5;
      14: atan_step = 3;
      15: atan_step = 1;
      default: atan_step = 0;
    endcase
  endfunction
endpackage

// File: rtl/fc_phase_acc.sv
module fc_phase_acc #(
  parameter int PH_W      = 16,
  parameter int INT_W     = 10,
  parameter int SUB_SHIFT = 5,
  parameter int FRAC_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_en,
  input  logic signed [INT_W-1:0]  int_off,
  input  logic signed [FRAC_W-1:0] frac_off,
  output logic [PH_W-1:0]          phase
);
  logic [PH_W-1:0] phase_q, phase_d, step_w;

  always_comb begin
    step_w  = (PH_W'(int_off) << SUB_SHIFT) + PH_W'(frac_off);
    phase_d = phase_q;
    if (step_en) phase_d = phase_q + step_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R7: phase frozen while no sample is accepted
  a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> phase == $past(phase));
endmodule

// File: rtl/fc_cordic.sv
module fc_cordic #(
  parameter int PH_W  = 16,
  parameter int CW    = 18,
  parameter int FRAC  = 16,
  parameter int ITER  = 14,
  parameter int TAG_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_en,
  input  logic [PH_W-1:0]      phase,
  input  logic [TAG_W-1:0]     tag_in,
  output logic                 out_en,
  output logic signed [CW-1:0] cos_o,
  output logic signed [CW-1:0] sin_o,
  output logic [TAG_W-1:0]     tag_o
);
  import fc_pkg::*;
  localparam int SH     = ANG_W - PH_W;
  localparam int K_INIT = int'(0.6072529350088812 * real'(1 << FRAC));
  localparam int LIM    = (1 << FRAC) + (1 << (FRAC - 6));

  logic signed [CW-1:0]    x_w   [0:ITER];
  logic signed [CW-1:0]    y_w   [0:ITER];
  logic signed [ANG_W-1:0] z_w   [0:ITER];
  logic [1:0]              qd_w  [0:ITER];
  logic                    vld_w [0:ITER];
  logic [TAG_W-1:0]        tag_w [0:ITER];

  // pre-stage: quadrant split, residual in [-45deg, +45deg)
  logic [PH_W-1:0]         shifted;
  logic [ANG_W-1:0]        res_wide;
  logic signed [ANG_W-1:0] z0_d;
  logic signed [CW-1:0]    x0_q, y0_q;
  logic signed [ANG_W-1:0] z0_q;
  logic [1:0]              qd0_q;
  logic                    vld0_q;
  logic [TAG_W-1:0]        tag0_q;

  always_comb begin
    shifted  = phase + PH_W'(1 << (PH_W - 3));
    res_wide = ANG_W'(shifted[PH_W-3:0]) << SH;
    z0_d     = $signed(res_wide - (ANG_W'(1) << (ANG_W - 3)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld0_q <= 1'b0;
      x0_q   <= '0;
      y0_q   <= '0;
      z0_q   <= '0;
      qd0_q  <= '0;
      tag0_q <= '0;
    end else begin
      vld0_q <= in_en;
      if (in_en) begin
        x0_q   <= CW'(K_INIT);
        y0_q   <= '0;
        z0_q   <= z0_d;
        qd0_q  <= shifted[PH_W-1 -: 2];
        tag0_q <= tag_in;
      end
    end
  end

  assign x_w[0]   = x0_q;
  assign y_w[0]   = y0_q;
  assign z_w[0]   = z0_q;
  assign qd_w[0]  = qd0_q;
  assign vld_w[0] = vld0_q;
  assign tag_w[0] = tag0_q;

  for (genvar i = 0; i < ITER; i++) begin : g_stage
    localparam logic signed [ANG_W-1:0] ATAN = ANG_W'(atan_step(i));
    logic signed [CW-1:0]    x_d, y_d, x_q, y_q, xs, ys;
    logic signed [ANG_W-1:0] z_d, z_q;
    logic [1:0]              qd_q;
    logic                    vld_q;
    logic [TAG_W-1:0]        tag_q;

    always_comb begin
      xs = x_w[i] >>> i;
      ys = y_w[i] >>> i;
      if (!z_w[i][ANG_W-1]) begin
        x_d = x_w[i] - ys;
        y_d = y_w[i] + xs;
        z_d = z_w[i] - ATAN;
      end else begin
        x_d = x_w[i] + ys;
        y_d = y_w[i] - xs;
        z_d = z_w[i] + ATAN;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        x_q   <= '0;
        y_q   <= '0;
        z_q   <= '0;
        qd_q  <= '0;
        tag_q <= '0;
      end else begin
        vld_q <= vld_w[i];
        if (vld_w[i]) begin
          x_q   <= x_d;
          y_q   <= y_d;
          z_q   <= z_d;
          qd_q  <= qd_w[i];
          tag_q <= tag_w[i];
        end
      end
    end

    assign x_w[i+1]   = x_q;
    assign y_w[i+1]   = y_q;
    assign z_w[i+1]   = z_q;
    assign qd_w[i+1]  = qd_q;
    assign vld_w[i+1] = vld_q;
    assign tag_w[i+1] = tag_q;
  end

  // quadrant restore
  logic signed [CW-1:0] c_d, s_d, c_q, s_q;
  logic                 en_q;
  logic [TAG_W-1:0]     tg_q;

  always_comb begin
    case (qd_w[ITER])
      2'd0:    begin c_d =  x_w[ITER]; s_d =  y_w[ITER]; end
      2'd1:    begin c_d = -y_w[ITER]; s_d =  x_w[ITER]; end
      2'd2:    begin c_d = -x_w[ITER]; s_d = -y_w[ITER]; end
      default: begin c_d =  y_w[ITER]; s_d = -x_w[ITER]; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      c_q  <= '0;
      s_q  <= '0;
      tg_q <= '0;
    end else begin
      en_q <= vld_w[ITER];
      if (vld_w[ITER]) begin
        c_q  <= c_d;
        s_q  <= s_d;
        tg_q <= tag_w[ITER];
      end
    end
  end

  assign out_en = en_q;
  assign cos_o  = c_q;
  assign sin_o  = s_q;
  assign tag_o  = tg_q;

  // R5: restored coefficients stay on the unit circle scale
  a_r5_coef_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (cos_o <= CW'(LIM) && cos_o >= -CW'(LIM) &&
                sin_o <= CW'(LIM) && sin_o >= -CW'(LIM)));
  // R5: residual angle driven toward zero by the last iteration
  a_r5_residual_small: assert property (@(posedge clk) disable iff (!rst_n)
    vld_w[ITER] |-> (z_w[ITER] <= ANG_W'(64) && z_w[ITER] >= -ANG_W'(64)));
endmodule

// File: rtl/fc_rotator.sv
module fc_rotator #(
  parameter int DW   = 12,
  parameter int CW   = 18,
  parameter int FRAC = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_en,
  input  logic signed [DW-1:0] di,
  input  logic signed [DW-1:0] dq,
  input  logic signed [CW-1:0] c,
  input  logic signed [CW-1:0] s,
  output logic                 out_en,
  output logic signed [DW-1:0] oi,
  output logic signed [DW-1:0] oq
);
  localparam int PW   = DW + CW;
  localparam int SW   = PW + 2;
  localparam int RNDI = 1 << (FRAC - 1);
  localparam logic signed [SW-1:0] MAXV = SW'((1 << (DW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -SW'(1 << (DW - 1));

  // four product registers: I*cos, Q*sin, Q*cos, I*sin
  logic signed [PW-1:0] p_ic_q, p_qs_q, p_qc_q, p_is_q;
  logic signed [PW-1:0] p_ic_d, p_qs_d, p_qc_d, p_is_d;
  logic                 mvld_q;

  always_comb begin
    p_ic_d = PW'(di) * PW'(c);
    p_qs_d = PW'(dq) * PW'(s);
    p_qc_d = PW'(dq) * PW'(c);
    p_is_d = PW'(di) * PW'(s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mvld_q <= 1'b0;
      p_ic_q <= '0;
      p_qs_q <= '0;
      p_qc_q <= '0;
      p_is_q <= '0;
    end else begin
      mvld_q <= in_en;
      if (in_en) begin
        p_ic_q <= p_ic_d;
        p_qs_q <= p_qs_d;
        p_qc_q <= p_qc_d;
        p_is_q <= p_is_d;
      end
    end
  end

  function automatic logic signed [DW-1:0] clamp(input logic signed [SW-1:0] v);
    if (v > MAXV)      clamp = MAXV[DW-1:0];
    else if (v < MINV) clamp = MINV[DW-1:0];
    else               clamp = v[DW-1:0];
  endfunction

  logic signed [SW-1:0] sum_i, sum_q, sh_i, sh_q;
  logic signed [DW-1:0] oi_d, oq_d, oi_q, oq_q;
  logic                 ovld_q;

  always_comb begin
    sum_i = SW'(p_ic_q) + SW'(p_qs_q) + SW'(RNDI);
    sum_q = SW'(p_qc_q) - SW'(p_is_q) + SW'(RNDI);
    sh_i  = sum_i >>> FRAC;
    sh_q  = sum_q >>> FRAC;
    oi_d  = clamp(sh_i);
    oq_d  = clamp(sh_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovld_q <= 1'b0;
      oi_q   <= '0;
      oq_q   <= '0;
    end else begin
      ovld_q <= mvld_q;
      if (mvld_q) begin
        oi_q <= oi_d;
        oq_q <= oq_d;
      end
    end
  end

  assign out_en = ovld_q;
  assign oi     = oi_q;
  assign oq     = oq_q;

  // R4: zero products give a zero corrected sample
  a_r4_zero_product: assert property (@(posedge clk) disable iff (!rst_n)
    (mvld_q && p_ic_q == 0 && p_qs_q == 0 && p_qc_q == 0 && p_is_q == 0)
      |=> (out_en && oi == 0 && oq == 0));
  // R6: saturation never flips the sign of the in-phase result
  a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mvld_q && p_ic_q >= 0 && p_qs_q >= 0) |=> oi >= 0);
endmodule

// File: rtl/freq_offset_comp.sv
module freq_offset_comp #(
  parameter int DW        = 12,
  parameter int PH_W      = 16,
  parameter int LOG2_NFFT = 11,
  parameter int INT_W     = 10,
  parameter int ITER      = 14,
  parameter int COEF_FRAC = 16,
  localparam int FRAC_W   = PH_W - LOG2_NFFT + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DW-1:0]     in_i,
  input  logic signed [DW-1:0]     in_q,
  input  logic signed [INT_W-1:0]  int_off,
  input  logic signed [FRAC_W-1:0] frac_off,
  output logic                     out_valid,
  output logic signed [DW-1:0]     out_i,
  output logic signed [DW-1:0]     out_q
);
  localparam int SUB_SHIFT = PH_W - LOG2_NFFT;
  localparam int CW        = COEF_FRAC + 2;
  localparam int TAG_W     = 2 * DW;
  localparam int LAT       = ITER + 4;
  localparam int CNT_W     = $clog2(LAT + 1) + 1;

  logic [PH_W-1:0]      phase;
  logic                 rot_en;
  logic signed [CW-1:0] cos_w, sin_w;
  logic [TAG_W-1:0]     tag_w;

  fc_phase_acc #(
    .PH_W(PH_W), .INT_W(INT_W), .SUB_SHIFT(SUB_SHIFT), .FRAC_W(FRAC_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .step_en(in_valid),
    .int_off(int_off), .frac_off(frac_off), .phase(phase)
  );

  fc_cordic #(
    .PH_W(PH_W), .CW(CW), .FRAC(COEF_FRAC), .ITER(ITER), .TAG_W(TAG_W)
  ) u_cordic (
    .clk(clk), .rst_n(rst_n), .in_en(in_valid), .phase(phase),
    .tag_in({in_i, in_q}), .out_en(rot_en), .cos_o(cos_w), .sin_o(sin_w),
    .tag_o(tag_w)
  );

  fc_rotator #(
    .DW(DW), .CW(CW), .FRAC(COEF_FRAC)
  ) u_rot (
    .clk(clk), .rst_n(rst_n), .in_en(rot_en),
    .di(tag_w[TAG_W-1 -: DW]), .dq(tag_w[DW-1:0]),
    .c(cos_w), .s(sin_w),
    .out_en(out_valid), .oi(out_i), .oq(out_q)
  );

  // samples in flight, for the ordering assertions
  logic [CNT_W-1:0] cnt_q, cnt_d;
  always_comb cnt_d = cnt_q + CNT_W'(in_valid) - CNT_W'(out_valid);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: no output without a sample having entered
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cnt_q != '0);
  // R8: nothing lingers beyond the pipeline depth
  a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LAT));
  // R1: outputs idle straight after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/freq_offset_comp_tb_top.sv
`timescale 1ns/1ps
module freq_offset_comp_tb_top;
  localparam int DW  = 12;
  localparam int LAT = 18;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [DW-1:0] in_i, in_q;
  logic signed [9:0] int_off;
  logic signed [5:0] frac_off;
  logic out_valid;
  logic signed [DW-1:0] out_i, out_q;

  always #4 clk = ~clk;

  freq_offset_comp dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .int_off(int_off), .frac_off(frac_off),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_i [0:4095];
  int exp_q [0:4095];
  string exp_tag [0:4095];
  int wr = 0, rd = 0;
  int phase_m = 0;
  int last_out_cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int sat(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // drive one valid sample at the falling edge and record the expectation
  task automatic send(input int i, input int q, input int io, input int fo, input string tag);
    real a, c, s;
    @(negedge clk);
    in_valid = 1'b1;
    in_i = DW'(i); in_q = DW'(q);
    int_off = 10'(io); frac_off = 6'(fo);
    a = 2.0 * 3.14159265358979 * real'(phase_m) / 65536.0;
    c = $cos(a); s = $sin(a);
    exp_i[wr % 4096] = sat(int'(real'(i) * c + real'(q) * s));
    exp_q[wr % 4096] = sat(int'(real'(q) * c - real'(i) * s));
    exp_tag[wr % 4096] = tag;
    wr++;
    phase_m = (phase_m + io * 32 + fo) & 16'hFFFF;
  endtask

  // idle cycles with junk on data and offsets (R7)
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_i = DW'($urandom_range(0, 4095));
      in_q = DW'($urandom_range(0, 4095));
      int_off = 10'($urandom_range(0, 1023));
      frac_off = 6'($urandom_range(0, 63));
    end
  endtask

  task automatic drain();
    idle(LAT + 4);
  endtask

  // output monitor, away from the rising edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      last_out_cyc = cyc;
      if (rd >= wr) begin
        check(1'b0, "R8", rd, wr);
      end else begin
        check(absd(int'(out_i), exp_i[rd % 4096]) <= 2, exp_tag[rd % 4096], int'(out_i), exp_i[rd % 4096]);
        check(absd(int'(out_q), exp_q[rd % 4096]) <= 2, exp_tag[rd % 4096], int'(out_q), exp_q[rd % 4096]);
        rd++;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    int t0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0; int_off = '0; frac_off = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_i == 0 && out_q == 0, "R1", int'(out_i), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);

    // R1/R8: first sample passes unrotated, latency measured
    t0 = cyc + 1;
    send(1000, -500, 256, 0, "R1");
    drain();
    check(last_out_cyc - t0 == LAT, "R8", last_out_cyc - t0, LAT);

    // R5: step by 45 degrees through the whole circle, incl. saturation (R6)
    send(2047, 2047, 256, 0, "R6");
    send(1000, 300, 256, 0, "R5");
    send(-700, 900, 256, 0, "R5");
    send(1500, -200, 256, 0, "R5");
    send(-2048, -2048, 256, 0, "R6");
    send(400, 1800, 256, 0, "R5");
    send(-1200, -30, 256, 0, "R5");
    send(2047, -2048, 256, 0, "R6");
    drain();

    // R9: negative integer offset wrapping through zero
    for (int k = 0; k < 6; k++) send(1800, -600, -1, 0, "R9");
    for (int k = 0; k < 4; k++) send(-900, 1300, -511, 0, "R9");
    // R2: fractional extremes and large integer combinations
    for (int k = 0; k < 5; k++) send(1024, 1024, 0, 31, "R2");
    for (int k = 0; k < 5; k++) send(-1024, 512, 0, -32, "R2");
    for (int k = 0; k < 4; k++) send(333, -777, 511, -32, "R2");
    // R3/R7: identical samples separated by junk idle cycles
    for (int k = 0; k < 6; k++) begin
      send(1500, 700, 37, 11, "R3");
      idle(k);
    end
    drain();

    // R4/R8: random stream with random gaps
    for (int k = 0; k < 600; k++) begin
      send(int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 4095)) - 2048,
           int'($urandom_range(0, 1023)) - 512, int'($urandom_range(0, 63)) - 32, "R4");
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    drain();
    check(rd == wr, "R8", rd, wr);

    // R1: reset mid-run restarts the phase at zero
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_i == 0 && out_q == 0, "R1", int'(out_valid), 0);
    rst_n = 1'b1;
    phase_m = 0;
    send(700, -300, 123, 7, "R1");
    send(700, -300, 0, 0, "R3");
    drain();
    check(rd == wr, "R8", rd, wr);
    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", rd, wr);
      summary();
    end
  end
endmodule